// File: doc/BRIEF.md
# Memory Access Ordering Gate

This block sits between an in-order issue stream and the memory system. Each cycle it looks at the oldest waiting memory operation (a load, store, acquire, release or fence) and decides whether that operation may be sent now. The decision uses a run-time consistency mode and five small counters, one per operation kind, that record how many operations of that kind are still in flight. A counter goes up when the gate grants an operation of its kind. It goes down when the memory system reports completion through the matching `op_done` bit. A store is reported complete only once every invalidation it caused has been acknowledged.

The mode selects which ordering arcs are enforced between plain loads and stores: sequential, total store order, partial store order, weak, or release style. Acquire, release and fence each carry their own ordering rule. When the gate holds an operation back, it reports why through a stall code. A requested mode change takes effect only at a moment when nothing is in flight. A completion that arrives for a kind with nothing outstanding raises a sticky error flag.

Top module: `mog_gate`

## Requirements
- R1: After reset all counters are zero, `active_mode` is 0 (sequential), `count_err` is 0, and with `op_valid` low `grant` is 0 and `stall_code` is 0.
- R2: With `active_mode` 0 (sequential), any operation is granted only when every counter is zero; otherwise `stall_code` is 4 (ordering).
- R3: With `active_mode` 1 (total store order), a load (kind 0) needs no outstanding load, and a store (kind 1) needs no outstanding load or store; outstanding stores do not hold back a load.
- R4: With `active_mode` 2 (partial store order), a load or a store needs only that no load is outstanding; outstanding stores hold back neither.
- R5: In modes 0 to 3, an acquire (kind 2) or release (kind 3) is granted only when every counter is zero. Plain loads and stores wait while any acquire or release is outstanding. In mode 3 (weak), plain loads and stores are otherwise free.
- R6: With `active_mode` 4 (release style), a load or store waits while an acquire is outstanding, but is not held back by outstanding releases, loads or stores.
- R7: With `active_mode` 4, a release waits until no load, store, acquire or release is outstanding.
- R8: With `active_mode` 4, an acquire waits only for outstanding acquires and releases, never for plain loads or stores.
- R9: A fence (kind 4; kind codes 5 to 7 also act as a fence) is granted only when every counter is zero. While any fence is outstanding, every operation stalls with `stall_code` 1.
- R10: Counters are 4 bits wide. An operation whose own kind's counter holds 15 stalls with `stall_code` 3.
- R11: An `op_done` bit (bit index equals the kind code) for a kind whose counter is zero sets `count_err`. The flag stays set until reset, and the counter stays at zero.
- R12: When `mode_req` (values above 4 read as 0) differs from `active_mode`, every operation stalls with `stall_code` 2. `active_mode` takes the requested value at the clock edge that ends a cycle in which all counters are zero, and never changes while any counter is non-zero.
- R13: Stall causes follow a fixed priority: fence outstanding (1), then mode change pending (2), then counter full (3), then ordering (4). With `op_valid` low, `grant` and `stall_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 3 | Requested consistency mode (0 sequential, 1 TSO, 2 PSO, 3 weak, 4 release style) |
| op_valid | input | 1 | An operation is waiting at the head of the stream |
| op_kind | input | 3 | Kind of the waiting operation (0 load, 1 store, 2 acquire, 3 release, 4 fence) |
| op_done | input | 5 | Per-kind completion pulse, bit index equals the kind code |
| grant | output | 1 | The waiting operation is issued this cycle |
| stall_code | output | 3 | Why it is held (0 none, 1 fence, 2 mode change, 3 counter full, 4 ordering) |
| active_mode | output | 3 | Mode currently enforced |
| count_err | output | 1 | Sticky flag for a completion with nothing outstanding |

## Verification
The bench first runs directed sequences. These show the fence barrier against ordinary ordering, a load passing an outstanding store in total store order but not in sequential mode, and a release waiting on plain accesses in release style while a later load passes that release. Further directed cases fill one counter to 15 in weak mode so the full stall appears without any ordering stall. Others request a mode change with an access in flight, which separates the drain hold from the switch itself, and send a completion with nothing outstanding. Random mixes of all five kinds under random completion timing and occasional mode changes then compare grant and stall code against a reference model. A swapped priority or a wrong arc in any mode shows up as a wrong code or an early grant.

// File: rtl/mog_pkg.sv
package mog_pkg;

    localparam int NUM_KINDS = 5;
    localparam int CNT_W     = 4;
    localparam int KIND_W    = 3;
    localparam int MODE_W    = 3;
    localparam int WHY_W     = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_SEQ  = 3'd0,
        MODE_TSO  = 3'd1,
        MODE_PSO  = 3'd2,
        MODE_WEAK = 3'd3,
        MODE_REL  = 3'd4
    } ord_mode_e;

    typedef enum logic [KIND_W-1:0] {
        OP_LD  = 3'd0,
        OP_ST  = 3'd1,
        OP_ACQ = 3'd2,
        OP_REL = 3'd3,
        OP_FEN = 3'd4
    } op_kind_e;

    typedef enum logic [WHY_W-1:0] {
        WHY_NONE  = 3'd0,
        WHY_FENCE = 3'd1,
        WHY_MODE  = 3'd2,
        WHY_FULL  = 3'd3,
        WHY_ORDER = 3'd4
    } stall_e;

    // one flag per kind: counter non-zero; bit position equals kind code
    typedef struct packed {
        logic fen;
        logic rel;
        logic acq;
        logic st;
        logic ld;
    } busy_t;

    function automatic ord_mode_e norm_mode(input logic [MODE_W-1:0] raw);
        if (raw > 3'd4) return MODE_SEQ;
        return ord_mode_e'(raw);
    endfunction

    function automatic op_kind_e norm_kind(input logic [KIND_W-1:0] raw);
        if (raw > 3'd4) return OP_FEN;
        return op_kind_e'(raw);
    endfunction

    // ordering arcs only; fence-outstanding, mode change and saturation are
    // decided ahead of this by the caller
    function automatic logic order_ok(input ord_mode_e m, input op_kind_e k,
                                      input busy_t b);
        logic sync_busy;
        logic any_busy;
        logic ok;
        sync_busy = b.acq | b.rel;
        any_busy  = b.ld | b.st | sync_busy | b.fen;
        ok = 1'b0;
        case (k)
            OP_FEN: ok = !any_busy;
            OP_ACQ: ok = (m == MODE_REL) ? !sync_busy : !any_busy;
            OP_REL: ok = (m == MODE_REL) ? !(b.ld | b.st | sync_busy) : !any_busy;
            default: begin
                case (m)
                    MODE_TSO:  ok = (k == OP_LD) ? !(b.ld | sync_busy)
                                                 : !(b.ld | b.st | sync_busy);
                    MODE_PSO:  ok = !(b.ld | sync_busy);
                    MODE_WEAK: ok = !sync_busy;
                    MODE_REL:  ok = !b.acq;
                    default:   ok = !any_busy;
                endcase
            end
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mog_counter.sv
module mog_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         full,
    output logic         busy,
    output logic         underflow
);
    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ZERO;
        end else begin
            case ({inc, dec})
                2'b10: if (count != TOP) count <= count + 1'b1;
                2'b01: if (count != ZERO) count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign full      = (count == TOP);
    assign busy      = (count != ZERO);
    assign underflow = dec && !inc && (count == ZERO);

endmodule

// File: rtl/mog_mode_hold.sv
module mog_mode_hold
    import mog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              drained,
    output ord_mode_e         mode_now,
    output logic              change_pending
);
    ord_mode_e want;

    assign want           = norm_mode(mode_req);
    assign change_pending = (want != mode_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_now <= MODE_SEQ;
        end else if (drained && change_pending) begin
            mode_now <= want;
        end
    end

endmodule

// File: rtl/mog_decide.sv
module mog_decide
    import mog_pkg::*;
(
    input  logic                 op_valid,
    input  op_kind_e             kind,
    input  ord_mode_e            mode,
    input  busy_t                busy,
    input  logic [NUM_KINDS-1:0] full_vec,
    input  logic                 change_pending,
    output logic                 grant,
    output stall_e               why
);
    always_comb begin
        grant = 1'b0;
        why   = WHY_NONE;
        if (op_valid) begin
            if (busy.fen) begin
                why = WHY_FENCE;
            end else if (change_pending) begin
                why = WHY_MODE;
            end else if (full_vec[kind]) begin
                why = WHY_FULL;
            end else if (!order_ok(mode, kind, busy)) begin
                why = WHY_ORDER;
            end else begin
                grant = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mog_gate.sv
module mog_gate
    import mog_pkg::*;
#(
    parameter int CNT_WIDTH = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MODE_W-1:0]    mode_req,
    input  logic                 op_valid,
    input  logic [KIND_W-1:0]    op_kind,
    input  logic [NUM_KINDS-1:0] op_done,
    output logic                 grant,
    output logic [WHY_W-1:0]     stall_code,
    output logic [MODE_W-1:0]    active_mode,
    output logic                 count_err
);
    localparam int FLAT_W = NUM_KINDS * CNT_WIDTH;

    op_kind_e               kind_q;
    ord_mode_e              mode_now;
    logic                   change_pending;
    logic                   issue;
    logic                   drained;
    logic [NUM_KINDS-1:0]   nz_vec;
    logic [NUM_KINDS-1:0]   full_vec;
    logic [NUM_KINDS-1:0]   uf_vec;
    logic [FLAT_W-1:0]      cnt_flat;
    busy_t                  busy;
    stall_e                 why;
    logic                   err_q;

    assign kind_q  = norm_kind(op_kind);
    assign issue   = op_valid && grant;
    assign busy    = busy_t'(nz_vec);
    assign drained = (nz_vec == '0);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
        logic inc_k;
        assign inc_k = issue && (kind_q == op_kind_e'(k));
        mog_counter #(.W(CNT_WIDTH)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .inc       (inc_k),
            .dec       (op_done[k]),
            .count     (cnt_flat[k*CNT_WIDTH +: CNT_WIDTH]),
            .full      (full_vec[k]),
            .busy      (nz_vec[k]),
            .underflow (uf_vec[k])
        );
    end

    mog_mode_hold u_mode (
        .clk            (clk),
        .rst            (rst),
        .mode_req       (mode_req),
        .drained        (drained),
        .mode_now       (mode_now),
        .change_pending (change_pending)
    );

    mog_decide u_decide (
        .op_valid       (op_valid),
        .kind           (kind_q),
        .mode           (mode_now),
        .busy           (busy),
        .full_vec       (full_vec),
        .change_pending (change_pending),
        .grant          (grant),
        .why            (why)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (|uf_vec) begin
            err_q <= 1'b1;
        end
    end

    assign stall_code  = why;
    assign active_mode = mode_now;
    assign count_err   = err_q;

endmodule

// File: rtl/mog_checker.sv
module mog_checker #(
    parameter int CW = 4,
    parameter int NK = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic            grant,
    input logic [2:0]      stall_code,
    input logic [2:0]      active_mode,
    input logic            count_err,
    input logic [2:0]      kind,
    input logic [NK*CW-1:0] cnt_flat
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] c_ld, c_st, c_acq, c_rel, c_fen, c_own;
    assign c_ld  = cnt_flat[0*CW +: CW];
    assign c_st  = cnt_flat[1*CW +: CW];
    assign c_acq = cnt_flat[2*CW +: CW];
    assign c_rel = cnt_flat[3*CW +: CW];
    assign c_fen = cnt_flat[4*CW +: CW];
    assign c_own = cnt_flat[kind*CW +: CW];

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!grant && stall_code == 3'd0));

    assert_seq_all_done_R2: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 3'd0 && grant) |-> (cnt_flat == '0));

    assert_tso_store_order_R3: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 3'd1 && kind == 3'd1 && c_st != '0) |-> !grant);

    assert_rel_acq_guard_R6: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 3'd4 && kind <= 3'd1 && c_acq != '0) |-> !grant);

    assert_release_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 3'd4 && kind == 3'd3 && (c_ld != '0 || c_st != '0 || c_rel != '0))
        |-> !grant);

    assert_fence_barrier_R9: assert property (@(posedge clk) disable iff (rst)
        (c_fen != '0) |-> !grant);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        grant |-> (c_own != CMAX));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        count_err |=> count_err);

    assert_mode_held_R12: assert property (@(posedge clk) disable iff (rst)
        (cnt_flat != '0) |=> $stable(active_mode));

endmodule

bind mog_gate mog_checker #(.CW(CNT_WIDTH), .NK(mog_pkg::NUM_KINDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .grant       (grant),
    .stall_code  (stall_code),
    .active_mode (active_mode),
    .count_err   (count_err),
    .kind        (kind_q),
    .cnt_flat    (cnt_flat)
);

// File: tb/tb_mog_gate.sv
module tb_mog_gate;

    localparam int CLK_PERIOD = 10;
    localparam int CSAT       = 15;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode_req;
    logic       op_valid;
    logic [2:0] op_kind;
    logic [4:0] op_done;
    logic       grant;
    logic [2:0] stall_code;
    logic [2:0] active_mode;
    logic       count_err;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt [5];
    int m_mode;
    bit m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    mog_gate dut (
        .clk         (clk),
        .rst         (rst),
        .mode_req    (mode_req),
        .op_valid    (op_valid),
        .op_kind     (op_kind),
        .op_done     (op_done),
        .grant       (grant),
        .stall_code  (stall_code),
        .active_mode (active_mode),
        .count_err   (count_err)
    );

    // expected ordering permission from the requirement text
    function automatic bit permit(int md, int k);
        bit ld = m_cnt[0] > 0;
        bit st = m_cnt[1] > 0;
        bit aq = m_cnt[2] > 0;
        bit rl = m_cnt[3] > 0;
        bit fe = m_cnt[4] > 0;
        bit anyb = ld || st || aq || rl || fe;
        if (k == 4) return !anyb;
        if (md == 4) begin
            if (k == 2) return !(aq || rl);
            if (k == 3) return !(ld || st || aq || rl);
            return !aq;
        end
        if (k >= 2) return !anyb;
        case (md)
            1: return (k == 0) ? !(ld || aq || rl) : !(ld || st || aq || rl);
            2: return !(ld || aq || rl);
            3: return !(aq || rl);
            default: return !anyb;
        endcase
    endfunction

    function automatic string tag_of(bit v, int md, int k, int why);
        if (!v) return "R13";
        if (why == 1 || k == 4) return "R9";
        if (why == 2) return "R12";
        if (why == 3) return "R10";
        if (md == 4) return (k == 2) ? "R8" : (k == 3) ? "R7" : "R6";
        if (k >= 2 || md == 3) return "R5";
        if (md == 1) return "R3";
        if (md == 2) return "R4";
        return "R2";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, int k, int md, logic [4:0] dn, string force_tag = "");
        bit g;
        int why;
        bit drained;
        string tag;
        @(negedge clk);
        op_valid = v;
        op_kind  = 3'(k);
        mode_req = 3'(md);
        op_done  = dn;
        #1;
        g = 0;
        why = 0;
        if (v) begin
            if (m_cnt[4] > 0) why = 1;
            else if (md != m_mode) why = 2;
            else if (m_cnt[k] == CSAT) why = 3;
            else if (!permit(m_mode, k)) why = 4;
            else g = 1;
        end
        tag = (force_tag != "") ? force_tag : tag_of(v, m_mode, k, why);
        check(grant == g, tag, "grant", int'(grant), int'(g));
        check(int'(stall_code) == why, tag, "stall_code", int'(stall_code), why);
        check(int'(active_mode) == m_mode, tag, "active_mode", int'(active_mode), m_mode);
        check(count_err == m_err, tag, "count_err", int'(count_err), int'(m_err));
        drained = 1;
        for (int j = 0; j < 5; j++) if (m_cnt[j] != 0) drained = 0;
        for (int j = 0; j < 5; j++) begin
            bit inc = v && g && (k == j);
            if (inc && !dn[j]) m_cnt[j]++;
            else if (!inc && dn[j]) begin
                if (m_cnt[j] == 0) m_err = 1;
                else m_cnt[j]--;
            end
        end
        if (drained && md != m_mode) m_mode = md;
    endtask

    task automatic drain(int md);
        for (int guard = 0; guard < 40; guard++) begin
            logic [4:0] dn;
            for (int j = 0; j < 5; j++) dn[j] = (m_cnt[j] > 0);
            if (dn == '0) break;
            step(0, 0, md, dn);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R13 watchdog: got 0 expected 1 (run finished)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        mode_req = '0; op_valid = 1'b0; op_kind = '0; op_done = '0;
        for (int j = 0; j < 5; j++) m_cnt[j] = 0;
        m_mode = 0;
        m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        step(0, 0, 0, 5'b0, "R1");

        // R9: fence then load stalls on fence; fence done, load goes
        step(1, 4, 0, 5'b0);
        step(1, 0, 0, 5'b0);
        step(1, 0, 0, 5'b10000);
        step(1, 0, 0, 5'b0);
        // R2: store behind outstanding load stalls in sequential mode
        step(1, 1, 0, 5'b0);
        // R12: request TSO with load in flight -> held, then switch
        step(1, 0, 1, 5'b0);
        step(1, 0, 1, 5'b00001);
        step(0, 0, 1, 5'b0);
        // R3: store then load bypasses it; second store waits
        step(1, 1, 1, 5'b0);
        step(1, 0, 1, 5'b0);
        step(1, 1, 1, 5'b0);
        drain(1);
        // R4: PSO stores pass stores
        step(0, 0, 2, 5'b0);
        step(1, 1, 2, 5'b0);
        step(1, 1, 2, 5'b0);
        step(1, 0, 2, 5'b0);
        drain(2);
        // R10: saturate load counter in weak mode
        step(0, 0, 3, 5'b0);
        for (int i = 0; i < CSAT; i++) step(1, 0, 3, 5'b0);
        step(1, 0, 3, 5'b0, "R10");
        // R5: acquire waits on plain accesses in weak mode
        step(1, 2, 3, 5'b0);
        drain(3);
        // R11: completion with nothing outstanding
        step(0, 0, 3, 5'b00010, "R11");
        step(0, 0, 3, 5'b0, "R11");
        // R6/R7/R8: release-style mode
        step(0, 0, 4, 5'b0);
        step(1, 0, 4, 5'b0);
        step(1, 2, 4, 5'b0);
        step(1, 1, 4, 5'b0);
        step(1, 1, 4, 5'b00100);
        step(1, 3, 4, 5'b0);
        step(1, 3, 4, 5'b00011);
        step(1, 0, 4, 5'b0);
        step(1, 2, 4, 5'b0);
        drain(4);

        // random mix
        begin
            int cur = 4;
            for (int i = 0; i < 3000; i++) begin
                int r;
                int k;
                bit v;
                logic [4:0] dn;
                if ($urandom % 60 == 0) cur = int'($urandom % 5);
                v = ($urandom % 4) != 0;
                r = int'($urandom % 8);
                k = (r < 3) ? 0 : (r < 6) ? 1 : r - 4;
                if ($urandom % 20 == 0) k = 4;
                for (int j = 0; j < 5; j++) dn[j] = (m_cnt[j] > 0) && ($urandom % 3 == 0);
                step(v, k, cur, dn);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule